// File: doc/BRIEF.md
# Stack Pointer Unit with Neighbour Values

This block keeps the pointer of a downward-growing stack that lives in external memory. Besides the current pointer it presents the pointer plus one and the pointer minus one at the same time. A processor with a single-cycle execute phase can then pick the right memory address for a push or a call (the current value) or for a pop or a return (the value plus one) without serial arithmetic.

The pointer changes through three strobes: a load of an immediate value, an increment and a decrement. The three presented values come from an output register stage that sits behind the pointer register. In the cycle in which a strobe is taken, the presented values still show the old pointer. They move to the new pointer on the next clock edge. The execute phase therefore sees stable addresses while the pointer itself is being updated.

Top module: `sp_unit`

## Requirements
- R1: A synchronous active-high reset sets the pointer to 0xFFF; one edge after reset, cur_o=0xFFF, prev_o=0x000 and next_o=0xFFE.
- R2: A decrement strobe (dec_i=1, no other strobe) lowers the pointer by one, as used after a push or a call.
- R3: An increment strobe (inc_i=1, no other strobe) raises the pointer by one, as used for a pop or a return.
- R4: At all times prev_o equals cur_o+1 and next_o equals cur_o-1, modulo 4096.
- R5: A load strobe replaces the pointer with the 12-bit value on load_val_i.
- R6: When strobes coincide, load wins over increment, and increment wins over decrement.
- R7: Increment and decrement wrap modulo 4096 (0xFFF+1=0x000, 0x000-1=0xFFF), with no flag raised.
- R8: A strobe sampled at clock edge k leaves the outputs unchanged after edge k and shows the new pointer after edge k+1.
- R9: With no strobe asserted, the pointer and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the pointer from load_val_i |
| load_val_i | input | 12 | Immediate value for a load |
| inc_i | input | 1 | Increment the pointer |
| dec_i | input | 1 | Decrement the pointer |
| cur_o | output | 12 | Registered current pointer |
| prev_o | output | 12 | Registered pointer plus one |
| next_o | output | 12 | Registered pointer minus one |

## Verification
The hardest case to bring about from the ports is the one-cycle freeze. The outputs must keep the old pointer exactly in the cycle after the strobe edge, and this is visible only if the bench samples between the two edges. Each stimulus vector is therefore held for one edge and then released. The outputs are checked once at the following falling edge, where they must still show the old value, and once after the next rising edge, where they must show the new value. Wrap-around at both ends of the range and all combinations of coinciding strobes are placed in the vector table, so that each one passes through the same two-step check.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_W_DEF = 12;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_DEC  = 2'd1,
    OP_INC  = 2'd2,
    OP_LOAD = 2'd3
  } sp_op_e;

  localparam int N_VIEWS = 3;
  localparam int VIEW_CUR  = 0;
  localparam int VIEW_PREV = 1;
  localparam int VIEW_NEXT = 2;
endpackage

// File: rtl/sp_op_select.sv
module sp_op_select
  import sp_pkg::*;
(
  input  logic   load_i,
  input  logic   inc_i,
  input  logic   dec_i,
  output sp_op_e op_o
);
  always_comb begin
    if (load_i)     op_o = OP_LOAD;
    else if (inc_i) op_o = OP_INC;
    else if (dec_i) op_o = OP_DEC;
    else            op_o = OP_HOLD;
  end

  always_comb begin
    if (load_i) a_load_first_r6: assert (op_o == OP_LOAD);
  end
endmodule

// File: rtl/sp_adjacent.sv
module sp_adjacent #(
  parameter int W = 12
) (
  input  logic [W-1:0] ptr_i,
  output logic [W-1:0] plus_o,
  output logic [W-1:0] minus_o
);
  localparam logic [W-1:0] ONE = W'(1);

  assign plus_o  = ptr_i + ONE;
  assign minus_o = ptr_i - ONE;
endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
  import sp_pkg::*;
#(
  parameter int W = 12,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  sp_op_e       op_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] plus_i,
  input  logic [W-1:0] minus_i,
  output logic [W-1:0] ptr_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_o <= RESET_VAL;
    end else begin
      unique case (op_i)
        OP_LOAD: ptr_o <= load_val_i;
        OP_INC:  ptr_o <= plus_i;
        OP_DEC:  ptr_o <= minus_i;
        default: ptr_o <= ptr_o;
      endcase
    end
  end

  p_reset_r1: assert property (@(posedge clk_i)
    rst_i |=> ptr_o == RESET_VAL);
  p_dec_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    op_i == OP_DEC |=> ptr_o == $past(ptr_o) - ONE);
  p_inc_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    op_i == OP_INC |=> ptr_o == $past(ptr_o) + ONE);
  p_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    op_i == OP_LOAD |=> ptr_o == $past(load_val_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    op_i == OP_HOLD |=> $stable(ptr_o));
endmodule

// File: rtl/sp_present.sv
module sp_present
  import sp_pkg::*;
#(
  parameter int W = 12,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] plus_i,
  input  logic [W-1:0] minus_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] view_d [N_VIEWS];
  logic [W-1:0] view_q [N_VIEWS];
  logic [W-1:0] view_rst [N_VIEWS];

  assign view_d[VIEW_CUR]  = cur_i;
  assign view_d[VIEW_PREV] = plus_i;
  assign view_d[VIEW_NEXT] = minus_i;

  assign view_rst[VIEW_CUR]  = RESET_VAL;
  assign view_rst[VIEW_PREV] = RESET_VAL + ONE;
  assign view_rst[VIEW_NEXT] = RESET_VAL - ONE;

  for (genvar g = 0; g < N_VIEWS; g++) begin : g_view
    always_ff @(posedge clk_i) begin
      if (rst_i) view_q[g] <= view_rst[g];
      else       view_q[g] <= view_d[g];
    end
  end

  assign cur_o  = view_q[VIEW_CUR];
  assign prev_o = view_q[VIEW_PREV];
  assign next_o = view_q[VIEW_NEXT];

  p_neigh_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (prev_o == cur_o + ONE) && (next_o == cur_o - ONE));
endmodule

// File: rtl/sp_unit.sv
module sp_unit
  import sp_pkg::*;
#(
  parameter int W = SP_W_DEF,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] next_o
);
  sp_op_e       op;
  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_plus;
  logic [W-1:0] ptr_minus;

  sp_op_select u_sel (
    .load_i (load_i),
    .inc_i  (inc_i),
    .dec_i  (dec_i),
    .op_o   (op)
  );

  sp_adjacent #(.W(W)) u_adj (
    .ptr_i   (ptr_q),
    .plus_o  (ptr_plus),
    .minus_o (ptr_minus)
  );

  sp_ptr_reg #(.W(W), .RESET_VAL(RESET_VAL)) u_ptr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .op_i       (op),
    .load_val_i (load_val_i),
    .plus_i     (ptr_plus),
    .minus_i    (ptr_minus),
    .ptr_o      (ptr_q)
  );

  sp_present #(.W(W), .RESET_VAL(RESET_VAL)) u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cur_i   (ptr_q),
    .plus_i  (ptr_plus),
    .minus_i (ptr_minus),
    .cur_o   (cur_o),
    .prev_o  (prev_o),
    .next_o  (next_o)
  );

  p_lag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> cur_o == $past(ptr_q));
  p_inc_over_dec_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (inc_i && dec_i && !load_i) |=> ptr_q == $past(ptr_q) + W'(1));
endmodule

// File: tb/tb_sp_unit.sv
module tb_sp_unit;
  localparam int W = 12;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld = 1'b0, inc = 1'b0, dec = 1'b0;
  logic [W-1:0] imm = '0;
  logic [W-1:0] cur, prev, nxt;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sp_unit #(.W(W)) dut (
    .clk_i(clk), .rst_i(rst), .load_i(ld), .load_val_i(imm),
    .inc_i(inc), .dec_i(dec), .cur_o(cur), .prev_o(prev), .next_o(nxt)
  );

  // {ld, inc, dec, imm, expected pointer}
  localparam logic [26:0] VEC [NV] = '{
    {3'b001, 12'h000, 12'hFFE},  // R2
    {3'b001, 12'h000, 12'hFFD},  // R2
    {3'b010, 12'h000, 12'hFFE},  // R3
    {3'b100, 12'h123, 12'h123},  // R5
    {3'b110, 12'h456, 12'h456},  // R6 load over inc
    {3'b011, 12'h000, 12'h457},  // R6 inc over dec
    {3'b100, 12'h000, 12'h000},  // R5
    {3'b001, 12'h000, 12'hFFF},  // R7 wrap down
    {3'b010, 12'h000, 12'h000},  // R7 wrap up
    {3'b000, 12'h777, 12'h000},  // R9 hold
    {3'b111, 12'hABC, 12'hABC},  // R6 all three
    {3'b001, 12'h000, 12'hABB}   // R2
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic [W-1:0] p);
    chk(tag, cur, p);
    chk({tag, " R4 prev"}, prev, p + 12'd1);
    chk({tag, " R4 next"}, nxt, p - 12'd1);
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] old;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk3("R1 reset", 12'hFFF);

    for (int i = 0; i < NV; i++) begin
      old = cur;
      @(negedge clk);
      {ld, inc, dec} = VEC[i][26:24];
      imm = VEC[i][23:12];
      @(negedge clk);
      {ld, inc, dec} = 3'b000;
      chk3("R8 frozen", old);
      @(negedge clk);
      chk3($sformatf("vec%0d", i), VEC[i][11:0]);
    end

    // back-to-back decrements: lag of exactly one edge, R2 R8
    @(negedge clk);
    dec = 1'b1;
    @(negedge clk);
    chk3("R8 b2b e1", 12'hABB);
    @(negedge clk);
    chk3("R8 b2b e2", 12'hABA);
    @(negedge clk);
    dec = 1'b0;
    chk3("R8 b2b e3", 12'hAB9);
    @(negedge clk);
    chk3("R2 b2b end", 12'hAB8);

    // R9 idle cycles keep value
    repeat (3) @(negedge clk);
    chk3("R9 idle", 12'hAB8);

    // R1 reset mid-run after a load
    ld = 1'b1; imm = 12'h200;
    @(negedge clk);
    ld = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk3("R1 midrun", 12'hFFF);
    @(negedge clk);
    chk3("R1 after", 12'hFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule